// File: doc/BRIEF.md
# DMA Channel Interrupt Combiner

This block gathers per-channel completion events from a multi-channel DMA engine and turns them into a small number of interrupt lines. The default build has 16 channels and 2 lines. Each channel reports completion as a one-cycle pulse on one bit of `done_i`. The pulse sets a sticky bit in a shared raw status register, and software clears that bit by writing a one to it.

Each interrupt line has its own slice of state. An enable mask selects which channels reach the line. A software force mask injects requests as if the channel were active. A read-only masked status view shows the requests that currently drive the line. The line itself is the OR of its masked status. Because the two lines share one raw status register, one channel can be routed to either line, to both, or to neither.

All register access goes through one plain write port and one combinational read port. Both take a register index. The block has no streaming data path, so it has no valid/ready handshake. A write always lands in the cycle it is presented and cannot be held off.

Top module: `irq_combiner`

## Requirements
- R1: After reset, the raw status, every enable mask and every force mask read as zero, and every interrupt line is low.
- R2: A one on bit n of `done_i` at a rising edge sets raw status bit n. The bit stays set on later cycles until software clears it.
- R3: A write to index 0 (raw status) clears every raw bit whose write-data bit is 1. Raw bits whose write-data bit is 0 are left unchanged.
- R4: When a completion pulse and a clear hit the same raw bit at the same edge, the pulse wins and the bit ends up set.
- R5: Line L's enable mask is written and read at index 1+3L. Reading index 3+3L returns that line's masked status, which is (raw OR force_L) AND enable_L.
- R6: Line L's force mask is written and read at index 2+3L. A force bit that is 1 and also enabled asserts the line with no channel activity. A force bit stays set until software writes it back to 0.
- R7: `irq_o[L]` is high exactly when line L's masked status is non-zero.
- R8: A write to one line's enable or force index leaves the other line's masks and output unchanged.
- R9: A write to a masked-status index changes no register in the block.
- R10: With 2 lines, index 7 is unmapped. Reading it returns zero, and writing it changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_i | input | NUM_CH | Completion pulses, one bit per channel |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW (3) | Register index for read and write |
| reg_wdata_i | input | NUM_CH | Write data |
| reg_rdata_o | output | NUM_CH | Read data for `reg_addr_i`, combinational |
| irq_o | output | NUM_LINES | Interrupt lines |

## Verification
A completion pulse or a register write is captured at the next rising edge. Read data and the interrupt lines are combinational from the registers, so each result is due in the cycle that follows that edge. The bench stamps every expected item with the cycle in which it is due. It changes the read index just after a rising edge and compares at the falling edge of the stamped cycle, which leaves no race with the edge. The corner cases are a pulse and a clear on the same edge, forced requests with an idle channel, and writes to read-only or unmapped indices. Each of these is followed by a readback of every register the stimulus could have touched.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;
  // Register index 0 is the shared raw status; line L uses 1+3L .. 3+3L.
  localparam int unsigned RawIdx = 0;

  function automatic int unsigned en_idx(input int unsigned line);
    return 1 + 3 * line;
  endfunction

  function automatic int unsigned frc_idx(input int unsigned line);
    return 2 + 3 * line;
  endfunction

  function automatic int unsigned sts_idx(input int unsigned line);
    return 3 + 3 * line;
  endfunction

  function automatic int unsigned idx_count(input int unsigned lines);
    return 1 + 3 * lines;
  endfunction
endpackage

// File: rtl/irq_raw_status.sv
module irq_raw_status #(
  parameter int NUM_CH = 16,
  parameter int AW     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] done_i,
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] raw_o
);
  import irq_comb_pkg::*;

  logic              hit;
  logic [NUM_CH-1:0] clr_mask;

  assign hit      = wr_i && (addr_i == AW'(RawIdx));
  assign clr_mask = hit ? wdata_i : '0;

  // Set term is ORed after the clear so a pulse wins on a collision.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_o <= '0;
    else         raw_o <= (raw_o & ~clr_mask) | done_i;
  end
endmodule

// File: rtl/irq_line.sv
module irq_line #(
  parameter int NUM_CH = 16,
  parameter int AW     = 3,
  parameter int LINE   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [NUM_CH-1:0] wdata_i,
  input  logic [NUM_CH-1:0] raw_i,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] frc_o,
  output logic [NUM_CH-1:0] sts_o,
  output logic              irq_o
);
  import irq_comb_pkg::*;

  localparam logic [AW-1:0] EnA  = AW'(en_idx(LINE));
  localparam logic [AW-1:0] FrcA = AW'(frc_idx(LINE));

  logic en_we, frc_we;
  assign en_we  = wr_i && (addr_i == EnA);
  assign frc_we = wr_i && (addr_i == FrcA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= '0;
      frc_o <= '0;
    end else begin
      if (en_we)  en_o  <= wdata_i;
      if (frc_we) frc_o <= wdata_i;
    end
  end

  assign sts_o = (raw_i | frc_o) & en_o;
  assign irq_o = |sts_o;
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux #(
  parameter int NUM_CH    = 16,
  parameter int NUM_LINES = 2,
  parameter int AW        = 3
) (
  input  logic [AW-1:0]                       addr_i,
  input  logic [NUM_CH-1:0]                   raw_i,
  input  logic [NUM_LINES-1:0][NUM_CH-1:0]    en_i,
  input  logic [NUM_LINES-1:0][NUM_CH-1:0]    frc_i,
  input  logic [NUM_LINES-1:0][NUM_CH-1:0]    sts_i,
  output logic [NUM_CH-1:0]                   rdata_o
);
  import irq_comb_pkg::*;

  // Unmapped indices fall through to zero.
  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(RawIdx)) rdata_o = raw_i;
    for (int l = 0; l < NUM_LINES; l++) begin
      if (addr_i == AW'(en_idx(l)))  rdata_o = en_i[l];
      if (addr_i == AW'(frc_idx(l))) rdata_o = frc_i[l];
      if (addr_i == AW'(sts_idx(l))) rdata_o = sts_i[l];
    end
  end
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner #(
  parameter  int NUM_CH    = 16,
  parameter  int NUM_LINES = 2,
  localparam int AW        = $clog2(irq_comb_pkg::idx_count(NUM_LINES))
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CH-1:0]    done_i,
  input  logic                 reg_wr_i,
  input  logic [AW-1:0]        reg_addr_i,
  input  logic [NUM_CH-1:0]    reg_wdata_i,
  output logic [NUM_CH-1:0]    reg_rdata_o,
  output logic [NUM_LINES-1:0] irq_o
);
  logic [NUM_CH-1:0]                raw_q;
  logic [NUM_LINES-1:0][NUM_CH-1:0] en_q;
  logic [NUM_LINES-1:0][NUM_CH-1:0] frc_q;
  logic [NUM_LINES-1:0][NUM_CH-1:0] sts_w;

  irq_raw_status #(.NUM_CH(NUM_CH), .AW(AW)) u_raw (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (done_i),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .raw_o   (raw_q)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    irq_line #(.NUM_CH(NUM_CH), .AW(AW), .LINE(l)) u_line (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (reg_wr_i),
      .addr_i  (reg_addr_i),
      .wdata_i (reg_wdata_i),
      .raw_i   (raw_q),
      .en_o    (en_q[l]),
      .frc_o   (frc_q[l]),
      .sts_o   (sts_w[l]),
      .irq_o   (irq_o[l])
    );
  end

  irq_read_mux #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES), .AW(AW)) u_rd (
    .addr_i  (reg_addr_i),
    .raw_i   (raw_q),
    .en_i    (en_q),
    .frc_i   (frc_q),
    .sts_i   (sts_w),
    .rdata_o (reg_rdata_o)
  );
endmodule

// File: rtl/irq_combiner_chk.sv
module irq_combiner_chk #(
  parameter  int NUM_CH    = 16,
  parameter  int NUM_LINES = 2,
  localparam int AW        = $clog2(irq_comb_pkg::idx_count(NUM_LINES))
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [NUM_CH-1:0]                done_i,
  input logic                             reg_wr,
  input logic [AW-1:0]                    reg_addr,
  input logic [NUM_CH-1:0]                reg_wdata,
  input logic [NUM_LINES-1:0]             irq_o,
  input logic [NUM_CH-1:0]                raw_q,
  input logic [NUM_LINES-1:0][NUM_CH-1:0] en_q,
  input logic [NUM_LINES-1:0][NUM_CH-1:0] frc_q
);
  import irq_comb_pkg::*;

  AST_PULSE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & $past(done_i)) == $past(done_i))); // R4

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(RawIdx)) |=>
      ((raw_q & $past(reg_wdata & ~done_i)) == '0)); // R3

  AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == AW'(RawIdx)) |=>
      ((raw_q & $past(raw_q)) == $past(raw_q))); // R2

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_chk
    AST_FORCE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_addr == AW'(frc_idx(l))) |=> $stable(frc_q[l])); // R6

    AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_addr == AW'(en_idx(l))) |=> $stable(en_q[l])); // R8

    AST_LINE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[l] |-> (((raw_q | frc_q[l]) & en_q[l]) != '0)); // R7
  end
endmodule

bind irq_combiner irq_combiner_chk #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES)) u_chk (
  .clk       (clk_i),
  .rst_n     (rst_ni),
  .done_i    (done_i),
  .reg_wr    (reg_wr_i),
  .reg_addr  (reg_addr_i),
  .reg_wdata (reg_wdata_i),
  .irq_o     (irq_o),
  .raw_q     (raw_q),
  .en_q      (en_q),
  .frc_q     (frc_q)
);

// File: tb/tb_irq_combiner.sv
module tb_irq_combiner;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;
  localparam int NL  = 2;
  localparam int AW  = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] done = '0;
  logic           wr = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [NCH-1:0] wdata = '0;
  logic [NCH-1:0] rdata;
  logic [NL-1:0]  irq;

  irq_combiner #(.NUM_CH(NCH), .NUM_LINES(NL)) dut (
    .clk_i (clk), .rst_ni (rst_n), .done_i (done), .reg_wr_i (wr),
    .reg_addr_i (addr), .reg_wdata_i (wdata), .reg_rdata_o (rdata), .irq_o (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int             due;
    logic [NCH-1:0] rd;
    logic [NL-1:0]  ln;
    string          tag;
  } item_t;

  item_t sb[$];
  int    checks = 0;
  int    errors = 0;
  bit    done_run = 0;

  // Reference state after the most recently driven edge.
  logic [NCH-1:0] m_raw = '0;
  logic [NCH-1:0] m_en [NL];
  logic [NCH-1:0] m_frc[NL];

  function automatic logic [NCH-1:0] m_read(input int a);
    if (a == 0) return m_raw;
    for (int l = 0; l < NL; l++) begin
      if (a == 1 + 3*l) return m_en[l];
      if (a == 2 + 3*l) return m_frc[l];
      if (a == 3 + 3*l) return (m_raw | m_frc[l]) & m_en[l];
    end
    return '0;
  endfunction

  function automatic logic [NL-1:0] m_irq();
    logic [NL-1:0] v;
    for (int l = 0; l < NL; l++) v[l] = |((m_raw | m_frc[l]) & m_en[l]);
    return v;
  endfunction

  task automatic drive(input logic w, input int a, input logic [NCH-1:0] d,
                       input logic [NCH-1:0] dn);
    @(posedge clk); #1;
    wr = w; addr = AW'(a); wdata = d; done = dn;
    m_raw = (m_raw & ~((w && a == 0) ? d : '0)) | dn;
    if (w) begin
      for (int l = 0; l < NL; l++) begin
        if (a == 1 + 3*l) m_en[l]  = d;
        if (a == 2 + 3*l) m_frc[l] = d;
      end
    end
  endtask

  task automatic expect_rd(input int a, input string tag);
    item_t it;
    @(posedge clk); #1;
    wr = 1'b0; done = '0; addr = AW'(a);
    it.due = cyc; it.rd = m_read(a); it.ln = m_irq(); it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: compares due items half a cycle after the driver set the index.
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0 && sb[0].due == cyc) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (rdata !== it.rd) begin
          errors++;
          $display("FAIL %s rdata actual=%h expected=%h", it.tag, rdata, it.rd);
        end
        checks++;
        if (irq !== it.ln) begin
          errors++;
          $display("FAIL %s irq actual=%b expected=%b", it.tag, irq, it.ln);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done_run) begin
      errors++; checks++;
      $display("FAIL watchdog all-reqs actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < NL; l++) begin m_en[l] = '0; m_frc[l] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset values
    expect_rd(0, "R1 raw");
    expect_rd(1, "R1 en0");
    expect_rd(2, "R1 frc0");
    expect_rd(5, "R1 frc1");
    // R2: pulse sets, stays set
    drive(1'b0, 0, '0, 16'h0005);
    expect_rd(0, "R2 raw set");
    drive(1'b0, 0, '0, '0);
    drive(1'b0, 0, '0, '0);
    expect_rd(0, "R2 raw sticky");
    // R5/R7/R8: enable line 0 only
    drive(1'b1, 1, 16'h0004, '0);
    expect_rd(3, "R5 sts0");
    expect_rd(6, "R7 sts1 idle");
    expect_rd(4, "R8 en1 untouched");
    // R3: clear bit 2 only
    drive(1'b1, 0, 16'h0004, '0);
    expect_rd(0, "R3 partial clear");
    expect_rd(3, "R7 line0 drops");
    // R4: pulse bit 8 while clearing bits 0 and 8
    drive(1'b1, 0, 16'h0101, 16'h0100);
    expect_rd(0, "R4 pulse wins");
    // R6: force line 1 on idle channel 15
    drive(1'b1, 4, 16'h8000, '0);
    drive(1'b1, 5, 16'h8000, '0);
    expect_rd(6, "R6 forced sts1");
    expect_rd(1, "R8 en0 after line1 writes");
    drive(1'b0, 0, '0, '0);
    drive(1'b0, 0, '0, '0);
    expect_rd(5, "R6 force holds");
    drive(1'b1, 5, 16'h0000, '0);
    expect_rd(5, "R6 force released");
    // R9: write to masked status index
    drive(1'b1, 3, 16'hFFFF, '0);
    expect_rd(1, "R9 en0 kept");
    expect_rd(0, "R9 raw kept");
    expect_rd(3, "R9 sts0 kept");
    // R10: unmapped index
    drive(1'b1, 7, 16'hFFFF, '0);
    expect_rd(7, "R10 unmapped read");
    expect_rd(0, "R10 raw kept");
    expect_rd(2, "R10 frc0 kept");
    // All channels at once, then full clear
    drive(1'b0, 0, '0, 16'hFFFF);
    drive(1'b1, 1, 16'hFFFF, '0);
    expect_rd(3, "R5 all channels");
    drive(1'b1, 0, 16'hFFFF, '0);
    expect_rd(0, "R3 full clear");
    expect_rd(3, "R7 all clear");
    repeat (3) @(posedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R1 scoreboard residue actual=%0d expected=0", sb.size());
    end
    done_run = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule